// File: doc/BRIEF.md
# Serial Peripheral Master Shift Engine

This block is the controller side of an SPI link. A one-cycle start command hands it a transmit word and a frame setup. The setup covers word length (1 to 16 bits), bit order, wiring style, half-duplex direction, clock rate, and the guard times before and after the clock burst. The engine drives the serial clock and the outgoing data line. It gathers the incoming bits and, at the end of the frame, presents the received word with a one-cycle completion strobe.

There are two wiring styles. In four-wire mode, a separate outgoing line (`mosi`) and incoming line (`miso`) operate in full duplex, and an active-low select (`ss_n`) frames the transfer. In three-wire mode there is no select, and a single shared data line is used in half duplex. The engine drives that line through `mosi` with `mosi_oe` as its pad enable, and the pad's input comes back on `miso`. A direction input decides whether the frame sends or listens. The clock idles low. Data is launched on the falling edge and captured on the rising edge. All setup is taken at the start command and held for the whole frame.

Top module: `spi_master_engine`

## Requirements
- R1: After reset `sclk` is 0, `ss_n` is 1, `busy` and `done` are 0 and `rx_word` is 0.
- R2: `start` is taken only while `busy` is 0; a `start` pulse during a frame changes neither the bits sent nor the frame's length, and launches no second frame.
- R3: Each half period of `sclk` lasts exactly `half_div`+2 module clocks, so `sclk` never runs faster than one quarter of the module clock.
- R4: `busy` rises (and in four-wire mode `ss_n` falls) on the clock edge that takes `start`; the first rising `sclk` edge follows (2·`lead_dly`+1)·(`half_div`+2) clocks later.
- R5: From the last falling `sclk` edge to the end of the frame (`ss_n` rising in four-wire mode) is (2·`trail_dly`+1)·(`half_div`+2) clocks.
- R6: A frame has exactly `frame_bits_m1`+1 rising `sclk` edges; `tx_word` bits at or above that count are never sent, and `rx_word` bits at or above it read 0.
- R7: With `msb_first`=1 bit `frame_bits_m1` is sent first and the first received bit lands in bit `frame_bits_m1`; with `msb_first`=0 bit 0 is sent first and the first received bit lands in bit 0.
- R8: `mosi` changes only while `sclk` is low, and the value on `miso` is captured on the clock edge where `sclk` rises.
- R9: In four-wire mode (`three_wire`=0) `mosi_oe` is 1, `ss_n` is 0 for the whole frame, and `rx_word` holds the bits seen on `miso`.
- R10: In three-wire mode `ss_n` stays 1. With `dir_tx`=1 the line is driven (`mosi_oe`=1) and `rx_word` reports 0. With `dir_tx`=0, `mosi_oe` and `mosi` are 0 during the frame and `rx_word` holds the bits seen on `miso`. While idle, `mosi_oe` is 0.
- R11: `done` is a one-cycle pulse on the edge that ends the frame; `busy` falls on that same edge and `rx_word` updates there and holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| tx_word | input | 16 | Word to send, right-aligned |
| frame_bits_m1 | input | 4 | Frame length minus one |
| msb_first | input | 1 | 1: most significant bit first; 0: least significant first |
| three_wire | input | 1 | 1: shared data line, no select; 0: four-wire |
| dir_tx | input | 1 | Three-wire direction: 1 drive, 0 listen |
| lead_dly | input | 4 | Guard before the first clock edge, in clock periods |
| trail_dly | input | 4 | Guard after the last clock edge, in clock periods |
| half_div | input | 8 | Half-period length minus two, in module clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rx_word | output | 16 | Last received word, right-aligned |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low select (four-wire only) |
| mosi | output | 1 | Outgoing / shared data line value |
| mosi_oe | output | 1 | Drive enable for the data line |
| miso | input | 1 | Incoming data (shared line input in three-wire mode) |

## Verification
Every cycle, the embedded assertions check the following. The clock never toggles on two adjacent edges, and the tick generator never fires twice in a row. Select stays high in three-wire mode and low across a four-wire frame. The outgoing bit holds while the clock is high. The received word moves only on the completion strobe, the strobe lasts a single cycle, and the latched setup is frozen for the frame. Only the directed scenarios can show the counted values. These are the exact lead and trail lengths in module clocks, the number of clock pulses, and the bit sequence in each order. They also show the right-aligned assembly of received words, that a start pulse during a frame is dropped, and the drive and release of the shared line.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned MAX_BITS = 16;
    localparam int unsigned LEN_W    = $clog2(MAX_BITS);
    localparam int unsigned DLY_W    = 4;
    localparam int unsigned DIV_W    = 8;
    localparam int unsigned HCNT_W   = DLY_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spim_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len_m1;
        logic             msb_first;
        logic             three_wire;
        logic             dir_tx;
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] trail;
        logic [DIV_W-1:0] half_div;
    } spim_cfg_t;

    // Position in the word of the idx-th bit on the wire.
    function automatic logic [LEN_W-1:0] wire_pos(
        input logic [LEN_W-1:0] idx,
        input logic [LEN_W-1:0] len_m1,
        input logic             msb
    );
        return msb ? (len_m1 - idx) : idx;
    endfunction

    // A guard of n clock periods plus one half period, counted in half periods.
    function automatic logic [HCNT_W-1:0] guard_halves(input logic [DLY_W-1:0] n);
        return {n, 1'b0};
    endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] limit;

    assign limit = {1'b0, half_div} + 1'b1;
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: half period never shorter than two module clocks
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  spim_cfg_t        cfg_in,
    output spim_cfg_t        cfg_q,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             ss_n,
    output logic [LEN_W-1:0] bit_idx,
    output logic             load,
    output logic             sample,
    output logic             advance,
    output logic             finish
);
    spim_state_e       state;
    logic [HCNT_W-1:0] half_cnt;
    logic              lead_end;
    logic              last_bit;

    assign busy     = (state != ST_IDLE);
    assign load     = (state == ST_IDLE) && start;
    assign lead_end = (state == ST_LEAD) && (half_cnt == guard_halves(cfg_q.lead));
    assign last_bit = (bit_idx == cfg_q.len_m1);
    assign sample   = tick && (lead_end || ((state == ST_SHIFT) && !sclk));
    assign advance  = tick && (state == ST_SHIFT) && sclk && !last_bit;
    assign finish   = tick && (state == ST_TRAIL) &&
                      (half_cnt == guard_halves(cfg_q.trail));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            sclk     <= 1'b0;
            ss_n     <= 1'b1;
            done     <= 1'b0;
            half_cnt <= '0;
            bit_idx  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q    <= cfg_in;
                        state    <= ST_LEAD;
                        ss_n     <= cfg_in.three_wire;
                        half_cnt <= '0;
                        bit_idx  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (lead_end) begin
                            state <= ST_SHIFT;
                            sclk  <= 1'b1;
                        end else begin
                            half_cnt <= half_cnt + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (last_bit) begin
                                state    <= ST_TRAIL;
                                half_cnt <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (finish) begin
                            state <= ST_IDLE;
                            ss_n  <= 1'b1;
                            done  <= 1'b1;
                        end else begin
                            half_cnt <= half_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && ss_n));

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    assert_sclk_rate_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |=> $stable(sclk));

    assert_bit_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx <= cfg_q.len_m1));

    assert_select_low_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_q.three_wire) |-> !ss_n);

    assert_no_select_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_q.three_wire) |-> ss_n);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/spim_data.sv
module spim_data
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                sample,
    input  logic                advance,
    input  logic                finish,
    input  logic                sclk,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic                miso,
    input  logic [LEN_W-1:0]    len_in,
    input  logic                msb_in,
    input  logic [LEN_W-1:0]    len_q,
    input  logic                msb_q,
    input  logic                discard_rx,
    input  logic [LEN_W-1:0]    bit_idx,
    output logic                mosi_q,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_acc;
    logic [LEN_W-1:0]    next_pos;
    logic [LEN_W-1:0]    cur_pos;

    assign next_pos = wire_pos(bit_idx + 1'b1, len_q, msb_q);
    assign cur_pos  = wire_pos(bit_idx, len_q, msb_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_acc  <= '0;
            mosi_q  <= 1'b0;
            rx_word <= '0;
        end else begin
            if (load) begin
                tx_q   <= tx_word;
                rx_acc <= '0;
                mosi_q <= tx_word[wire_pos('0, len_in, msb_in)];
            end else if (advance) begin
                mosi_q <= tx_q[next_pos];
            end else if (finish) begin
                mosi_q <= 1'b0;
            end
            if (sample) begin
                rx_acc[cur_pos] <= miso;
            end
            if (finish) begin
                rx_word <= discard_rx ? '0 : rx_acc;
            end
        end
    end

    assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi_q));

    assert_rx_only_at_end_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> $past(finish));

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    frame_bits_m1,
    input  logic                msb_first,
    input  logic                three_wire,
    input  logic                dir_tx,
    input  logic [DLY_W-1:0]    lead_dly,
    input  logic [DLY_W-1:0]    trail_dly,
    input  logic [DIV_W-1:0]    half_div,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                sclk,
    output logic                ss_n,
    output logic                mosi,
    output logic                mosi_oe,
    input  logic                miso
);
    spim_cfg_t        cfg_in;
    spim_cfg_t        cfg_q;
    logic             tick;
    logic [LEN_W-1:0] bit_idx;
    logic             load;
    logic             sample;
    logic             advance;
    logic             finish;
    logic             mosi_q;

    assign cfg_in = '{len_m1:     frame_bits_m1,
                      msb_first:  msb_first,
                      three_wire: three_wire,
                      dir_tx:     dir_tx,
                      lead:       lead_dly,
                      trail:      trail_dly,
                      half_div:   half_div};

    spim_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half_div (cfg_q.half_div),
        .tick     (tick)
    );

    spim_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .busy    (busy),
        .done    (done),
        .sclk    (sclk),
        .ss_n    (ss_n),
        .bit_idx (bit_idx),
        .load    (load),
        .sample  (sample),
        .advance (advance),
        .finish  (finish)
    );

    spim_data u_data (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .sample     (sample),
        .advance    (advance),
        .finish     (finish),
        .sclk       (sclk),
        .tx_word    (tx_word),
        .miso       (miso),
        .len_in     (frame_bits_m1),
        .msb_in     (msb_first),
        .len_q      (cfg_q.len_m1),
        .msb_q      (cfg_q.msb_first),
        .discard_rx (cfg_q.three_wire && cfg_q.dir_tx),
        .bit_idx    (bit_idx),
        .mosi_q     (mosi_q),
        .rx_word    (rx_word)
    );

    assign mosi_oe = busy ? (!cfg_q.three_wire || cfg_q.dir_tx) : !three_wire;
    assign mosi    = mosi_oe && mosi_q;

    // R10: a listening frame on the shared line never drives it
    assert_line_released_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_q.three_wire && !cfg_q.dir_tx) |-> (!mosi_oe && !mosi));

    // R4: a taken start makes the engine busy on the next edge
    assert_start_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
module test_spi_master_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] tx_word = '0;
    logic [3:0]  frame_bits_m1 = '0;
    logic        msb_first = 1'b0;
    logic        three_wire = 1'b0;
    logic        dir_tx = 1'b0;
    logic [3:0]  lead_dly = '0;
    logic [3:0]  trail_dly = '0;
    logic [7:0]  half_div = '0;
    logic        busy, done, sclk, ss_n, mosi, mosi_oe;
    logic [15:0] rx_word;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_master_engine i_spi_master_engine (
        .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
        .frame_bits_m1(frame_bits_m1), .msb_first(msb_first),
        .three_wire(three_wire), .dir_tx(dir_tx), .lead_dly(lead_dly),
        .trail_dly(trail_dly), .half_div(half_div), .busy(busy), .done(done),
        .rx_word(rx_word), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .mosi_oe(mosi_oe), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic wbit(input logic [15:0] w, input int len_m1,
                                  input bit msb, input int i);
        return msb ? w[len_m1 - i] : w[i];
    endfunction

    initial begin
        #1000000;
        errors++;
        $display("FAIL R11 watchdog: actual timeout expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // One frame with every timing and data check; poke pulses start mid-frame.
    task automatic run_frame(input int len_m1, input bit msb, input bit tw,
                             input bit dir, input int lead, input int trail,
                             input int half, input logic [15:0] txw,
                             input logic [15:0] slvw, input bit poke);
        int   hp = half + 2;
        int   n = 0;
        int   rises = 0;
        int   first_rise = -1;
        int   last_fall = -1;
        int   last_tog = -1;
        int   done_n = -1;
        int   sidx = 0;
        bit   prev = 0;
        bit   bad_spacing = 0;
        bit   bad_oe = 0;
        bit   bad_ss = 0;
        bit   bad_mosi_low = 0;
        logic [15:0] got = '0;
        logic [15:0] exp_tx = '0;
        logic [15:0] exp_rx = '0;
        logic [15:0] keep_rx;
        bit   listen = tw && !dir;
        for (int i = 0; i <= len_m1; i++) begin
            exp_tx[i] = wbit(txw, len_m1, msb, i);
            exp_rx[i] = slvw[i];
        end
        if (tw && dir) exp_rx = '0;

        @(negedge clk);
        tx_word = txw; frame_bits_m1 = 4'(len_m1); msb_first = msb;
        three_wire = tw; dir_tx = dir; lead_dly = 4'(lead);
        trail_dly = 4'(trail); half_div = 8'(half);
        miso = wbit(slvw, len_m1, msb, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(busy === 1'b1, "R4", "busy after start", int'(busy), 1);
        while (n < 20000) begin
            if (busy) begin
                if (mosi_oe !== !listen) bad_oe = 1;
                if (ss_n !== tw) bad_ss = 1;
                if (listen && mosi !== 1'b0) bad_mosi_low = 1;
            end
            if (sclk !== prev) begin
                if (first_rise >= 0 && (n - last_tog) != hp) bad_spacing = 1;
                last_tog = n;
            end
            if (sclk && !prev) begin
                if (first_rise < 0) first_rise = n;
                if (rises < 16) got[rises] = mosi;
                rises++;
            end
            if (!sclk && prev) begin
                last_fall = n;
                sidx++;
                if (sidx <= len_m1) miso = wbit(slvw, len_m1, msb, sidx);
            end
            prev = sclk;
            if (done) begin
                done_n = n;
                break;
            end
            if (poke && n == 5) begin
                start = 1'b1; tx_word = ~txw; frame_bits_m1 = 4'd15;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done_n > 0, "R11", "done seen", done_n, 1);
        chk(first_rise - 1 == (2*lead + 1) * hp, "R4", "lead cycles",
            first_rise - 1, (2*lead + 1) * hp);
        chk(done_n - last_fall == (2*trail + 1) * hp, "R5", "trail cycles",
            done_n - last_fall, (2*trail + 1) * hp);
        chk(rises == len_m1 + 1, "R6", "sclk pulses", rises, len_m1 + 1);
        chk(!bad_spacing, "R3", "half period", int'(bad_spacing), 0);
        if (!listen)
            chk(got == exp_tx, "R7", "bits sent", int'(got), int'(exp_tx));
        else
            chk(!bad_mosi_low, "R10", "line idle while listening", int'(bad_mosi_low), 0);
        chk(!bad_oe, tw ? "R10" : "R9", "mosi_oe in frame", int'(bad_oe), 0);
        chk(!bad_ss, tw ? "R10" : "R9", "ss_n in frame", int'(bad_ss), 0);
        chk(rx_word === exp_rx, "R8", "rx_word", int'(rx_word), int'(exp_rx));
        chk(busy === 1'b0, "R11", "busy falls with done", int'(busy), 0);
        keep_rx = rx_word;
        @(negedge clk);
        chk(done === 1'b0, "R11", "done one cycle", int'(done), 0);
        for (int k = 0; k < 10; k++) @(negedge clk);
        chk(busy === 1'b0 && rx_word === keep_rx, "R2", "no extra frame, rx held",
            int'(busy), 0);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk === 1'b0, "R1", "sclk", int'(sclk), 0);
        chk(ss_n === 1'b1, "R1", "ss_n", int'(ss_n), 1);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", int'({busy, done}), 0);
        chk(rx_word === 16'h0, "R1", "rx_word", int'(rx_word), 0);
    endtask

    task automatic t_fourwire_msb8;
        run_frame(7, 1, 0, 0, 1, 0, 0, 16'h00A5, 16'h003C, 0);   // R7 R9
    endtask

    task automatic t_fourwire_lsb16;
        run_frame(15, 0, 0, 0, 0, 2, 3, 16'hC35A, 16'h9E21, 0);  // R5 R7
    endtask

    task automatic t_single_bit;
        run_frame(0, 1, 0, 0, 0, 0, 1, 16'hFFFE, 16'hFFFF, 0);   // R6
    endtask

    task automatic t_msb12_slow;
        run_frame(11, 1, 0, 0, 3, 1, 2, 16'hF9B3, 16'h0A5F, 0);  // R6 R8
    endtask

    task automatic t_three_tx;
        run_frame(9, 0, 1, 1, 2, 1, 0, 16'h02D7, 16'h03FF, 0);   // R10
    endtask

    task automatic t_three_rx;
        run_frame(7, 1, 1, 0, 0, 0, 1, 16'h00FF, 16'h0096, 0);   // R10
    endtask

    task automatic t_start_while_busy;
        run_frame(5, 0, 0, 0, 1, 1, 1, 16'h0029, 16'h0012, 1);   // R2
    endtask

    task automatic t_three_idle_release;
        @(negedge clk);
        three_wire = 1'b1;
        @(negedge clk);
        chk(mosi_oe === 1'b0, "R10", "idle oe three-wire", int'(mosi_oe), 0);
        three_wire = 1'b0;
        @(negedge clk);
        chk(mosi_oe === 1'b1, "R9", "idle oe four-wire", int'(mosi_oe), 1);
    endtask

    initial begin
        t_reset();
        t_fourwire_msb8();
        t_fourwire_lsb16();
        t_single_bit();
        t_msb12_slow();
        t_three_tx();
        t_three_rx();
        t_start_while_busy();
        t_three_idle_release();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule